// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Controller

This block decides which of two programmed 3-bit current codes is sent to a PLL charge pump. A primary code serves steady-state tracking. A secondary code, normally a larger current, serves a boost period while the loop settles after a frequency change. Software starts a boost by writing 1 to a gain bit. The boost then ends in one of two ways. In manual mode, software ends it by writing 0 to the gain bit. In timed mode, the block counts phase-detector events and ends the boost by itself once a programmed number of events has passed. At that moment it also clears the stored gain bit, so its read-back value shows that the boost is over.

The block also drives the charge-pump output enable. This enable takes a three-state configuration bit and a power-down input into account. Power-down also holds the boost timer at its load value, and the timer stays there until power-down ends. Gain-bit writes are still accepted during power-down.

A small state machine with three states holds the behaviour. IDLE drives the primary code. HELD is the manual boost, which lasts until software clears it. TIMED is the boost that counts phase-detector events. The named transitions are:
- ENTER_HELD: IDLE or any boost state to HELD, on a write of 1 with fastlock enabled and manual mode selected.
- ENTER_TIMED / RESTART: IDLE or any boost state to TIMED, on a write of 1 with fastlock enabled and timed mode selected. The timer is reloaded.
- SW_CLEAR: any state to IDLE, on a write of 0, or on a write of 1 while fastlock is disabled.
- ENABLE_LOST: HELD or TIMED to IDLE, when the fastlock enable bit is 0.
- MODE_TO_HELD: TIMED to HELD, when the mode bit returns to manual.
- TIMEOUT: TIMED to IDLE, when the timer expires. This transition also clears the gain bit.

Top module: `fastlock_cp_ctrl`

## Requirements
- R1: After reset the gain read-back is 0 and the current code equals the primary code.
- R2: While fastlock enable is 0 the current code equals the primary code, even after a write of 1 to the gain bit. That write is still stored and reads back as 1.
- R3: With enable 1 and mode bit 0 (manual), a write of 1 makes the current code equal the secondary code from the next cycle on. It stays so through any number of phase-detector ticks until the gain bit is written.
- R4: A write of 0 to the gain bit clears the read-back to 0 and returns the current code to primary on the next cycle.
- R5: With enable 1 and mode bit 1 (timed), a write of 1 starts a boost. The boost ends on the cycle after the (4*TC+3)-th tick that follows the write cycle, where TC is the 4-bit timeout code. The read-back then becomes 0 and the current code becomes primary. After one tick fewer, the boost is still active.
- R6: A write of 1 during a timed boost reloads the timer, so the full 4*TC+3 ticks are counted again from that write.
- R7: The timer counts only in timed mode. If the mode bit returns to 0 during a timed boost, the boost continues as a manual boost and ticks no longer end it.
- R8: The output enable is 1 only when both the three-state bit and power-down are 0. It follows these inputs in the same cycle.
- R9: While power-down is 1, ticks do not end a boost and the timer is held at its load value. After release, a full 4*TC+3 ticks are needed. Gain writes during power-down take effect.
- R10: Clearing the enable bit during a boost returns the current to primary at once, and the read-back keeps its stored value. Setting the enable bit again does not restart the boost until a new write of 1.
- R11: A tick in the same cycle as a gain write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_enable | input | 1 | Fastlock enable configuration bit |
| fl_mode | input | 1 | 0 = manual boost end, 1 = timed boost end |
| tmo_code | input | 4 | Timeout code TC; boost length 4*TC+3 ticks |
| cur_primary | input | 3 | Steady-state current code |
| cur_secondary | input | 3 | Boost current code |
| cp_hiz | input | 1 | 1 = charge-pump output three-stated |
| gain_wr | input | 1 | Write strobe for the gain bit |
| gain_wdata | input | 1 | Value written to the gain bit |
| pd_tick | input | 1 | One-cycle pulse per phase-detector event |
| power_down | input | 1 | Power-down request |
| cur_code | output | 3 | Active current code |
| cp_oe | output | 1 | Charge-pump output enable |
| gain_rb | output | 1 | Read-back of the stored gain bit |

## Verification
The assertions check several relations on every cycle. The output enable drops under three-state or power-down. A disabled block, or a cleared gain bit, always drives the primary code. A write of 1 sets the read-back on the next cycle, and a write of 0 clears it. A stored gain bit never clears by itself while manual mode is selected or while power-down is active. The exact tick count at which a timed boost ends cannot be checked per cycle, and neither can the restart after a rewrite or the full reload after power-down. The bench's directed scenarios and a cycle-accurate model check these under random stimulus.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_HELD  = 2'd1,
        FL_TIMED = 2'd2
    } fl_state_e;

endpackage

// File: rtl/fl_timeout_timer.sv
module fl_timeout_timer #(
    parameter int CODE_W = 4,
    parameter int STEP   = 4,
    parameter int OFFSET = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              load_i,
    input  logic              hold_i,
    input  logic              run_i,
    input  logic              tick_i,
    output logic              expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // boost length in ticks: STEP * code + OFFSET
    assign load_val = CNT_W'(32'(STEP) * 32'(tmo_code) + 32'(OFFSET));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i || hold_i) begin
            cnt_q <= load_val;
        end else if (run_i && tick_i && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        expire_o = run_i && tick_i && !load_i && !hold_i && (cnt_q <= CNT_W'(1));
    end

endmodule

// File: rtl/fl_gain_fsm.sv
module fl_gain_fsm
    import fl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fl_enable,
    input  logic      fl_mode,
    input  logic      gain_wr,
    input  logic      gain_wdata,
    input  logic      expire_i,
    output fl_state_e state_o,
    output logic      gain_bit_o,
    output logic      run_o,
    output logic      load_o
);

    fl_state_e state_q;
    fl_state_e state_d;
    logic      gain_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // stored gain bit: software write wins over timeout clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= 1'b0;
        end else if (gain_wr) begin
            gain_q <= gain_wdata;
        end else if (expire_i) begin
            gain_q <= 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (gain_wr) begin
            if (gain_wdata && fl_enable) begin
                state_d = fl_mode ? FL_TIMED : FL_HELD;   // ENTER_HELD / ENTER_TIMED / RESTART
            end else begin
                state_d = FL_IDLE;                        // SW_CLEAR
            end
        end else begin
            unique case (state_q)
                FL_IDLE: begin
                    state_d = FL_IDLE;
                end
                FL_HELD: begin
                    if (!fl_enable) begin
                        state_d = FL_IDLE;                // ENABLE_LOST
                    end
                end
                FL_TIMED: begin
                    if (!fl_enable) begin
                        state_d = FL_IDLE;                // ENABLE_LOST
                    end else if (!fl_mode) begin
                        state_d = FL_HELD;                // MODE_TO_HELD
                    end else if (expire_i) begin
                        state_d = FL_IDLE;                // TIMEOUT
                    end
                end
                default: begin
                    state_d = FL_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        gain_bit_o = gain_q;
        load_o     = gain_wr;
        run_o      = (state_q == FL_TIMED) && fl_enable && fl_mode;
    end

endmodule

// File: rtl/fl_current_sel.sv
module fl_current_sel
    import fl_pkg::*;
#(
    parameter int CUR_W = 3
) (
    input  fl_state_e        state_i,
    input  logic             fl_enable,
    input  logic [CUR_W-1:0] cur_primary,
    input  logic [CUR_W-1:0] cur_secondary,
    input  logic             cp_hiz,
    input  logic             power_down,
    output logic [CUR_W-1:0] cur_code,
    output logic             cp_oe
);

    logic boost;

    always_comb begin
        boost    = fl_enable && (state_i != FL_IDLE);
        cur_code = boost ? cur_secondary : cur_primary;
        cp_oe    = !cp_hiz && !power_down;
    end

endmodule

// File: rtl/fastlock_cp_ctrl.sv
module fastlock_cp_ctrl
    import fl_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CUR_W  = 3,
    parameter int STEP   = 4,
    parameter int OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_enable,
    input  logic              fl_mode,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic [CUR_W-1:0]  cur_primary,
    input  logic [CUR_W-1:0]  cur_secondary,
    input  logic              cp_hiz,
    input  logic              gain_wr,
    input  logic              gain_wdata,
    input  logic              pd_tick,
    input  logic              power_down,
    output logic [CUR_W-1:0]  cur_code,
    output logic              cp_oe,
    output logic              gain_rb
);

    localparam int MAX_LEN = STEP * ((1 << CODE_W) - 1) + OFFSET;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    fl_state_e state;
    logic      run;
    logic      load;
    logic      expire;

    fl_gain_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fl_enable  (fl_enable),
        .fl_mode    (fl_mode),
        .gain_wr    (gain_wr),
        .gain_wdata (gain_wdata),
        .expire_i   (expire),
        .state_o    (state),
        .gain_bit_o (gain_rb),
        .run_o      (run),
        .load_o     (load)
    );

    fl_timeout_timer #(
        .CODE_W (CODE_W),
        .STEP   (STEP),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_code (tmo_code),
        .load_i   (load),
        .hold_i   (power_down),
        .run_i    (run),
        .tick_i   (pd_tick),
        .expire_o (expire)
    );

    fl_current_sel #(
        .CUR_W (CUR_W)
    ) sel_i (
        .state_i       (state),
        .fl_enable     (fl_enable),
        .cur_primary   (cur_primary),
        .cur_secondary (cur_secondary),
        .cp_hiz        (cp_hiz),
        .power_down    (power_down),
        .cur_code      (cur_code),
        .cp_oe         (cp_oe)
    );

endmodule

// File: rtl/fastlock_cp_ctrl_chk.sv
module fastlock_cp_ctrl_chk #(
    parameter int CUR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fl_enable,
    input logic             fl_mode,
    input logic [CUR_W-1:0] cur_primary,
    input logic             cp_hiz,
    input logic             gain_wr,
    input logic             gain_wdata,
    input logic             power_down,
    input logic [CUR_W-1:0] cur_code,
    input logic             cp_oe,
    input logic             gain_rb
);

    p_hiz_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cp_hiz |-> !cp_oe);

    p_pd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> !cp_oe);

    p_disabled_primary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_enable |-> (cur_code == cur_primary));

    p_cleared_primary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_rb |-> (cur_code == cur_primary));

    p_set_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr && gain_wdata) |=> gain_rb);

    p_clear_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr && !gain_wdata) |=> !gain_rb);

    p_manual_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_rb && !gain_wr && !fl_mode) |=> gain_rb);

    p_pd_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_rb && !gain_wr && power_down) |=> gain_rb);

endmodule

bind fastlock_cp_ctrl fastlock_cp_ctrl_chk #(.CUR_W(CUR_W)) chk_i (.*);

// File: tb/fastlock_cp_ctrl_tb_top.sv
`timescale 1ns/1ps
module fastlock_cp_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fl_enable = 1'b0;
    logic       fl_mode = 1'b0;
    logic [3:0] tmo_code = 4'd0;
    logic [2:0] cur_primary = 3'd1;
    logic [2:0] cur_secondary = 3'd6;
    logic       cp_hiz = 1'b0;
    logic       gain_wr = 1'b0;
    logic       gain_wdata = 1'b0;
    logic       pd_tick = 1'b0;
    logic       power_down = 1'b0;
    logic [2:0] cur_code;
    logic       cp_oe;
    logic       gain_rb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit m_bit = 1'b0;
    bit m_act = 1'b0;
    bit m_timed = 1'b0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    fastlock_cp_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fl_enable     (fl_enable),
        .fl_mode       (fl_mode),
        .tmo_code      (tmo_code),
        .cur_primary   (cur_primary),
        .cur_secondary (cur_secondary),
        .cp_hiz        (cp_hiz),
        .gain_wr       (gain_wr),
        .gain_wdata    (gain_wdata),
        .pd_tick       (pd_tick),
        .power_down    (power_down),
        .cur_code      (cur_code),
        .cp_oe         (cp_oe),
        .gain_rb       (gain_rb)
    );

    function automatic int len_of(input logic [3:0] tc);
        return 4 * int'(tc) + 3;
    endfunction

    function automatic logic [2:0] exp_cur();
        return (m_act && fl_enable) ? cur_secondary : cur_primary;
    endfunction

    function automatic logic exp_oe();
        return !cp_hiz && !power_down;
    endfunction

    // model update from inputs present at the clock edge
    task automatic model_edge();
        if (!rst_n) begin
            m_bit = 1'b0; m_act = 1'b0; m_timed = 1'b0; m_cnt = 0;
        end else if (gain_wr) begin
            m_bit = gain_wdata;
            m_act = gain_wdata && fl_enable;
            m_timed = fl_mode;
            m_cnt = len_of(tmo_code);
        end else begin
            if (m_act && !fl_enable) begin
                m_act = 1'b0;
            end else if (m_act && m_timed && !fl_mode) begin
                m_timed = 1'b0;
            end else if (m_act && m_timed && !power_down && pd_tick) begin
                if (m_cnt <= 1) begin
                    m_act = 1'b0; m_bit = 1'b0;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (power_down) m_cnt = len_of(tmo_code);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic wr_gain(input logic v);
        gain_wr = 1'b1; gain_wdata = v;
        cyc();
        gain_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            pd_tick = 1'b1;
            cyc();
        end
        pd_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1", "gain_rb", gain_rb, 0);
        chk("R1", "cur_code", cur_code, cur_primary);

        // R2 disabled: stored but primary
        fl_enable = 1'b0;
        wr_gain(1'b1);
        chk("R2", "gain_rb", gain_rb, 1);
        chk("R2", "cur_code", cur_code, 1);
        wr_gain(1'b0);

        // R3 manual boost survives ticks
        fl_enable = 1'b1; fl_mode = 1'b0; tmo_code = 4'd0;
        wr_gain(1'b1);
        chk("R3", "cur_code after set", cur_code, 6);
        ticks(100);
        chk("R3", "cur_code after ticks", cur_code, 6);
        chk("R3", "gain_rb after ticks", gain_rb, 1);

        // R4 software clear
        wr_gain(1'b0);
        chk("R4", "gain_rb", gain_rb, 0);
        chk("R4", "cur_code", cur_code, 1);

        // R5 timed boost, three codes
        fl_mode = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tmo_code = (k == 0) ? 4'd0 : (k == 1) ? 4'd2 : 4'd15;
            wr_gain(1'b1);
            ticks(len_of(tmo_code) - 1);
            chk("R5", "gain_rb one tick early", gain_rb, 1);
            chk("R5", "cur_code one tick early", cur_code, 6);
            ticks(1);
            chk("R5", "gain_rb at timeout", gain_rb, 0);
            chk("R5", "cur_code at timeout", cur_code, 1);
        end

        // R11 tick during write not counted
        tmo_code = 4'd0;
        gain_wr = 1'b1; gain_wdata = 1'b1; pd_tick = 1'b1;
        cyc();
        gain_wr = 1'b0;
        ticks(2);
        chk("R11", "gain_rb after 2 ticks", gain_rb, 1);
        ticks(1);
        chk("R11", "gain_rb after 3 ticks", gain_rb, 0);

        // R6 restart
        tmo_code = 4'd2;
        wr_gain(1'b1);
        ticks(5);
        wr_gain(1'b1);
        ticks(10);
        chk("R6", "gain_rb after restart", gain_rb, 1);
        ticks(1);
        chk("R6", "gain_rb at timeout", gain_rb, 0);

        // R7 mode returns to manual mid-run
        wr_gain(1'b1);
        ticks(4);
        fl_mode = 1'b0;
        cyc();
        ticks(60);
        chk("R7", "gain_rb manual", gain_rb, 1);
        chk("R7", "cur_code manual", cur_code, 6);
        wr_gain(1'b0);
        fl_mode = 1'b1;

        // R9 power-down holds and reloads timer
        wr_gain(1'b1);
        ticks(6);
        power_down = 1'b1;
        ticks(20);
        chk("R9", "gain_rb in pd", gain_rb, 1);
        chk("R8", "cp_oe in pd", cp_oe, 0);
        power_down = 1'b0;
        cyc();
        ticks(10);
        chk("R9", "gain_rb after reload", gain_rb, 1);
        ticks(1);
        chk("R9", "gain_rb full length", gain_rb, 0);
        power_down = 1'b1;
        wr_gain(1'b1);
        chk("R9", "write during pd", gain_rb, 1);
        wr_gain(1'b0);
        power_down = 1'b0;

        // R10 enable loss
        fl_mode = 1'b0;
        wr_gain(1'b1);
        fl_enable = 1'b0;
        #0;
        chk("R10", "cur_code enable low", cur_code, 1);
        cyc();
        chk("R10", "gain_rb kept", gain_rb, 1);
        fl_enable = 1'b1;
        cyc();
        chk("R10", "cur_code reenabled", cur_code, 1);
        wr_gain(1'b0);

        // R8 enable combinations
        for (int c = 0; c < 4; c++) begin
            cp_hiz = c[0]; power_down = c[1];
            #1;
            chk("R8", "cp_oe", cp_oe, (c == 0) ? 1 : 0);
        end
        cp_hiz = 1'b0; power_down = 1'b0;

        // random phase against model (R2..R11)
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 20000; n++) begin
            pd_tick = ($urandom % 2) == 0;
            gain_wr = ($urandom % 24) == 0;
            gain_wdata = ($urandom % 3) != 0;
            if (($urandom % 200) == 0) fl_enable = ~fl_enable;
            if (($urandom % 150) == 0) fl_mode = ~fl_mode;
            if (($urandom % 100) == 0) tmo_code = 4'($urandom);
            if (($urandom % 120) == 0) power_down = ~power_down;
            if (($urandom % 60) == 0) cp_hiz = ~cp_hiz;
            if (($urandom % 80) == 0) begin
                cur_primary = 3'($urandom); cur_secondary = 3'($urandom);
            end
            #0;
            chk("R3", "random cur_code", cur_code, exp_cur());
            chk("R8", "random cp_oe", cp_oe, exp_oe());
            chk("R5", "random gain_rb", gain_rb, m_bit);
            cyc();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule